// File: doc/BRIEF.md
# Interrupt Source Sensing Stage

This block sits in front of the priority and distribution logic for one processor interface. It collects every raw interrupt source and turns it into one pending bit per interrupt ID. Sixteen software IDs are raised by a write strobe. Seven private peripheral lines are always level-sensitive. A parameterised bank of shared lines can each be set to rising-edge or level sensing. Every external line passes through a two-flop synchronizer before it is sensed.

After reset the interface is disabled. While it stays disabled, the two active-low legacy request pins drive the processor's fast and normal request outputs directly, and they do not show up in the pending vector. A single enable write hands those pins over to normal sensing. From then on they appear as level-sensitive pending IDs, like the other private lines.

Top module: `irq_sense_top`

## Requirements
- R1: While reset is asserted, and right after it, every pending bit is 0 and the interface is disabled.
- R2: A software write with `sgi_wr`=1 and ID `sgi_id` (0..15) sets pending bit `sgi_id` at the next clock edge. The bit stays set whatever the inputs do, until it is cleared.
- R3: A clear with `clr_wr`=1 and `clr_id` drops the pending bit at the next edge, but only for a software ID or for a shared ID whose line is in edge mode. A clear that targets a level-sensitive ID has no effect.
- R4: When a set event (a software write, or a detected rising edge) and a clear for the same ID fall in the same cycle, the bit ends up set.
- R5: The private lines map to fixed IDs: `ppi_maint`→25, `ppi_hyp_tmr`→26, `ppi_virt_tmr`→27, `ppi_sec_tmr`→29, `ppi_ns_tmr`→30. These lines are active-high and level-sensitive. A pending bit follows its line two clock edges after the line changes.
- R6: `leg_fiq_n` maps to ID 28 and `leg_irq_n` maps to ID 31. Both are active-low and level-sensitive. They show as pending only while the interface is enabled.
- R7: While the interface is disabled, `fiq_req` = NOT `leg_fiq_n` and `irq_req` = NOT `leg_irq_n`, combinationally. While it is enabled, both outputs are 0.
- R8: IDs 16 to 24 are never pending.
- R9: Shared line k maps to ID 32+k. With `spi_edge_cfg[k]`=0 it is active-high and level-sensitive, and the pending bit follows the line two edges after the line changes.
- R10: With `spi_edge_cfg[k]`=1, a rising transition of line k sets pending bit 32+k at the third edge after the line rises. The bit then stays set after the line falls.
- R11: While a shared line is in level mode, its edge-mode pending state is cleared. Switching the line back to edge mode therefore shows no stale pending bit.
- R12: `if_en_wr`=1 loads `if_en_val` into the interface enable at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en_wr | input | 1 | Interface enable write strobe |
| if_en_val | input | 1 | Value loaded into the interface enable |
| sgi_wr | input | 1 | Software interrupt write strobe |
| sgi_id | input | 4 | Software interrupt ID to raise |
| clr_wr | input | 1 | Pending clear strobe |
| clr_id | input | ID_W | ID to clear |
| ppi_maint | input | 1 | Maintenance line, active-high |
| ppi_hyp_tmr | input | 1 | Hypervisor timer line, active-high |
| ppi_virt_tmr | input | 1 | Virtual timer line, active-high |
| leg_fiq_n | input | 1 | Legacy fast request pin, active-low |
| ppi_sec_tmr | input | 1 | Secure physical timer line, active-high |
| ppi_ns_tmr | input | 1 | Non-secure physical timer line, active-high |
| leg_irq_n | input | 1 | Legacy normal request pin, active-low |
| spi_in | input | SPI_W | Shared interrupt lines |
| spi_edge_cfg | input | SPI_W | Per shared line: 1 = edge, 0 = level |
| pend | output | NUM_IDS | Pending bit per interrupt ID |
| fiq_req | output | 1 | Fast request output (bypass path) |
| irq_req | output | 1 | Normal request output (bypass path) |

## Verification
The embedded properties check, on every cycle, these behaviours:
- a software write sets its bit one edge later;
- a set bit stays set unless a clear for it arrives;
- a detected edge in edge mode sets its bit, and wins a same-cycle race against a clear;
- the enable register loads, the bypass outputs go quiet once enabled, and the legacy IDs stay hidden while disabled.

The bench scenarios cover what only an end-to-end sequence can show: the two- and three-edge latencies from a pin to its pending bit, the active-low polarity, and that a clear of a level ID is ignored. They also cover that a mode switch discards stale edge state and that the reserved IDs stay silent while random traffic runs against an independent model.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  localparam int SGI_COUNT = 16;
  localparam int PPI_COUNT = 7;
  localparam int PPI_BASE  = 25;
  localparam int SPI_BASE  = 32;
  localparam int RSV_LO    = 16;
  localparam int RSV_HI    = 24;

  // index of each private line inside the private vector; ID = PPI_BASE + index
  typedef enum logic [2:0] {
    PPI_MAINT    = 3'd0,
    PPI_HYP_TMR  = 3'd1,
    PPI_VIRT_TMR = 3'd2,
    PPI_LEG_FIQ  = 3'd3,
    PPI_SEC_TMR  = 3'd4,
    PPI_NS_TMR   = 3'd5,
    PPI_LEG_IRQ  = 3'd6
  } ppi_idx_e;

  // polarity per private line: 1 = active-low
  localparam logic [PPI_COUNT-1:0] PPI_ACT_LOW = 7'b100_1000;

  function automatic int ppi_id(input int k);
    return PPI_BASE + k;
  endfunction

  function automatic int spi_id(input int k);
    return SPI_BASE + k;
  endfunction

  function automatic logic level_asserted(input logic s, input logic act_low);
    return s ^ act_low;
  endfunction

  function automatic logic is_legacy(input int k);
    return (k == int'(PPI_LEG_FIQ)) || (k == int'(PPI_LEG_IRQ));
  endfunction

  // next value of an edge-latched pending bit; set beats clear
  function automatic logic edge_next(input logic cur, input logic set,
                                     input logic clr, input logic keep);
    return keep & ((cur & ~clr) | set);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_sgi_bank.sv
module irq_sgi_bank
  import irq_sense_pkg::*;
#(
  parameter int N  = SGI_COUNT,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [IW-1:0] wr_id,
  input  logic [N-1:0]  clr_hit,
  output logic [N-1:0]  pend
);
  logic [N-1:0] set_hit;
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_sgi
    assign set_hit[i] = wr && (wr_id == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= edge_next(pend_q[i], set_hit[i], clr_hit[i], 1'b1);
    end

    p_sgi_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[i] |=> pend_q[i]);

    p_sgi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !clr_hit[i]) |=> pend_q[i]);

    p_sgi_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[i] && !set_hit[i]) |=> !pend_q[i]);

    p_sgi_race_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[i] && set_hit[i]) |=> pend_q[i]);
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_spi_sense.sv
module irq_spi_sense
  import irq_sense_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_s,
  input  logic [N-1:0] edge_cfg,
  input  logic [N-1:0] clr_hit,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;
  logic [N-1:0] edge_q;
  logic [N-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= line_s;
  end

  assign rise = line_s & ~prev_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) edge_q[i] <= 1'b0;
      else        edge_q[i] <= edge_next(edge_q[i], rise[i], clr_hit[i], edge_cfg[i]);
    end

    assign pend[i] = edge_cfg[i] ? edge_q[i] : level_asserted(line_s[i], 1'b0);

    p_edge_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_cfg[i] && rise[i]) |=> edge_q[i]);

    p_edge_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_cfg[i] && edge_q[i] && !clr_hit[i]) |=> edge_q[i]);

    p_edge_race_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_cfg[i] && rise[i] && clr_hit[i]) |=> edge_q[i]);

    p_level_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_cfg[i] |=> !edge_q[i]);
  end
endmodule

// File: rtl/irq_sense_top.sv
module irq_sense_top
  import irq_sense_pkg::*;
#(
  parameter int NUM_SHARED  = 64,
  parameter int NUM_IDS     = SPI_BASE + NUM_SHARED,
  parameter int ID_W        = $clog2(NUM_IDS),
  parameter int SPI_W       = (NUM_SHARED > 0) ? NUM_SHARED : 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               if_en_wr,
  input  logic               if_en_val,
  input  logic               sgi_wr,
  input  logic [3:0]         sgi_id,
  input  logic               clr_wr,
  input  logic [ID_W-1:0]    clr_id,
  input  logic               ppi_maint,
  input  logic               ppi_hyp_tmr,
  input  logic               ppi_virt_tmr,
  input  logic               leg_fiq_n,
  input  logic               ppi_sec_tmr,
  input  logic               ppi_ns_tmr,
  input  logic               leg_irq_n,
  input  logic [SPI_W-1:0]   spi_in,
  input  logic [SPI_W-1:0]   spi_edge_cfg,
  output logic [NUM_IDS-1:0] pend,
  output logic               fiq_req,
  output logic               irq_req
);
  logic                  if_en_q;
  logic [PPI_COUNT-1:0]  ppi_raw;
  logic [PPI_COUNT-1:0]  ppi_s;
  logic [SGI_COUNT-1:0]  sgi_clr;
  logic [SGI_COUNT-1:0]  sgi_pend;
  logic [SPI_BASE-1:0]   low_pend;

  // interface enable: resets disabled so the bypass is active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        if_en_q <= 1'b0;
    else if (if_en_wr) if_en_q <= if_en_val;
  end

  // legacy bypass straight from the pins while disabled
  assign fiq_req = ~if_en_q & ~leg_fiq_n;
  assign irq_req = ~if_en_q & ~leg_irq_n;

  // private lines, ordered by index = ID - PPI_BASE
  assign ppi_raw = {leg_irq_n, ppi_ns_tmr, ppi_sec_tmr, leg_fiq_n,
                    ppi_virt_tmr, ppi_hyp_tmr, ppi_maint};

  irq_sync #(.W(PPI_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PPI_ACT_LOW)) i_ppi_sync (
    .clk(clk), .rst_n(rst_n), .d(ppi_raw), .q(ppi_s)
  );

  for (genvar i = 0; i < SGI_COUNT; i++) begin : g_sgi_clr
    assign sgi_clr[i] = clr_wr && (clr_id == ID_W'(i));
  end

  irq_sgi_bank #(.N(SGI_COUNT), .IW(4)) i_sgi (
    .clk(clk), .rst_n(rst_n), .wr(sgi_wr), .wr_id(sgi_id),
    .clr_hit(sgi_clr), .pend(sgi_pend)
  );

  always_comb begin
    low_pend = '0;
    low_pend[SGI_COUNT-1:0] = sgi_pend;
    for (int k = 0; k < PPI_COUNT; k++) begin
      low_pend[ppi_id(k)] = level_asserted(ppi_s[k], PPI_ACT_LOW[k]) &
                            (is_legacy(k) ? if_en_q : 1'b1);
    end
  end

  if (NUM_SHARED > 0) begin : g_spi
    logic [NUM_SHARED-1:0] spi_s;
    logic [NUM_SHARED-1:0] spi_clr;
    logic [NUM_SHARED-1:0] spi_pend;

    irq_sync #(.W(NUM_SHARED), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_spi_sync (
      .clk(clk), .rst_n(rst_n), .d(spi_in), .q(spi_s)
    );

    for (genvar k = 0; k < NUM_SHARED; k++) begin : g_spi_clr
      assign spi_clr[k] = clr_wr && (clr_id == ID_W'(spi_id(k)));
    end

    irq_spi_sense #(.N(NUM_SHARED)) i_spi (
      .clk(clk), .rst_n(rst_n), .line_s(spi_s), .edge_cfg(spi_edge_cfg),
      .clr_hit(spi_clr), .pend(spi_pend)
    );

    assign pend = {spi_pend, low_pend};
  end else begin : g_no_spi
    assign pend = low_pend;
  end

  p_en_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    if_en_wr |=> (if_en_q == $past(if_en_val)));

  p_bypass_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    if_en_q |-> (!fiq_req && !irq_req));

  p_legacy_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en_q |-> (!pend[ppi_id(int'(PPI_LEG_FIQ))] && !pend[ppi_id(int'(PPI_LEG_IRQ))]));

  p_reserved_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend[RSV_HI:RSV_LO] == '0);
endmodule

// File: tb/test_irq_sense_top.sv
module test_irq_sense_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 64;
  localparam int NI  = 32 + NS;
  localparam int IDW = 7;
  localparam logic [6:0] ACT_LOW = 7'b100_1000;

  logic clk = 1'b0;
  logic rst_n;
  logic if_en_wr, if_en_val, sgi_wr, clr_wr;
  logic [3:0] sgi_id;
  logic [IDW-1:0] clr_id;
  logic p_maint, p_hyp, p_virt, fiq_n, p_sec, p_ns, irq_n;
  logic [NS-1:0] spi_in, spi_cfg;
  logic [NI-1:0] pend;
  logic fiq_req, irq_req;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_sense_top i_irq_sense_top (
    .clk(clk), .rst_n(rst_n), .if_en_wr(if_en_wr), .if_en_val(if_en_val),
    .sgi_wr(sgi_wr), .sgi_id(sgi_id), .clr_wr(clr_wr), .clr_id(clr_id),
    .ppi_maint(p_maint), .ppi_hyp_tmr(p_hyp), .ppi_virt_tmr(p_virt),
    .leg_fiq_n(fiq_n), .ppi_sec_tmr(p_sec), .ppi_ns_tmr(p_ns), .leg_irq_n(irq_n),
    .spi_in(spi_in), .spi_edge_cfg(spi_cfg),
    .pend(pend), .fiq_req(fiq_req), .irq_req(irq_req)
  );

  // independent model built from the requirements
  logic [6:0]    m_p1, m_p2;
  logic [NS-1:0] m_s1, m_s2, m_prev, m_edge;
  logic [15:0]   m_sgi;
  logic          m_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 <= ACT_LOW; m_p2 <= ACT_LOW;
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_edge <= '0;
      m_sgi <= '0; m_en <= 1'b0;
    end else begin
      m_p1 <= {irq_n, p_ns, p_sec, fiq_n, p_virt, p_hyp, p_maint};
      m_p2 <= m_p1;
      m_s1 <= spi_in; m_s2 <= m_s1; m_prev <= m_s2;
      if (if_en_wr) m_en <= if_en_val;
      for (int k = 0; k < 16; k++) begin
        logic c, s;
        c = clr_wr && (int'(clr_id) == k);
        s = sgi_wr && (int'(sgi_id) == k);
        m_sgi[k] <= s ? 1'b1 : (c ? 1'b0 : m_sgi[k]);
      end
      for (int k = 0; k < NS; k++) begin
        logic c, r;
        c = clr_wr && (int'(clr_id) == 32 + k);
        r = m_s2[k] && !m_prev[k];
        if (!spi_cfg[k]) m_edge[k] <= 1'b0;
        else             m_edge[k] <= r ? 1'b1 : (c ? 1'b0 : m_edge[k]);
      end
    end
  end

  function automatic logic [NI-1:0] exp_pend();
    logic [NI-1:0] v = '0;
    v[15:0] = m_sgi;
    for (int k = 0; k < 7; k++) begin
      logic a;
      a = m_p2[k] ^ ACT_LOW[k];
      if (k == 3 || k == 6) a = a & m_en;
      v[25 + k] = a;
    end
    for (int k = 0; k < NS; k++) v[32 + k] = spi_cfg[k] ? m_edge[k] : m_s2[k];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; if_en_wr = 0; if_en_val = 0; sgi_wr = 0; sgi_id = 0;
    clr_wr = 0; clr_id = 0; p_maint = 0; p_hyp = 0; p_virt = 0; p_sec = 0;
    p_ns = 0; fiq_n = 1; irq_n = 1; spi_in = '0; spi_cfg = '0;
    tick(3);
    chk("R1 pend in reset", 128'(pend), 128'(0));
    chk("R1 fiq_req idle", 128'(fiq_req), 128'(0));
    rst_n = 1'b1;
    tick(2);
    chk("R1 pend after reset", 128'(pend), 128'(0));

    // bypass while disabled
    fiq_n = 0; #1;
    chk("R7 fiq bypass", 128'(fiq_req), 128'(1));
    irq_n = 0; #1;
    chk("R7 irq bypass", 128'(irq_req), 128'(1));
    irq_n = 1;
    tick(3);
    chk("R6 legacy hidden while disabled", 128'(pend[28]), 128'(0));

    // software IDs
    sgi_wr = 1; sgi_id = 5; tick(1); sgi_wr = 0;
    chk("R2 sgi set", 128'(pend[5]), 128'(1));
    tick(3);
    chk("R2 sgi sticky", 128'(pend[15:0]), 128'(16'h0020));
    clr_wr = 1; clr_id = 5; tick(1); clr_wr = 0;
    chk("R3 sgi clear", 128'(pend[5]), 128'(0));
    sgi_wr = 1; sgi_id = 7; clr_wr = 1; clr_id = 7; tick(1); sgi_wr = 0; clr_wr = 0;
    chk("R4 sgi set beats clear", 128'(pend[7]), 128'(1));
    sgi_wr = 1; sgi_id = 15; tick(1); sgi_wr = 0;
    chk("R8 reserved idle", 128'(pend[24:16]), 128'(0));
    clr_wr = 1; clr_id = 7; tick(1); clr_id = 15; tick(1); clr_wr = 0;

    // private level lines
    p_hyp = 1; tick(1);
    chk("R5 hyp not yet", 128'(pend[26]), 128'(0));
    tick(1);
    chk("R5 hyp at id26", 128'(pend[31:25]), 128'(7'b000_0010));
    clr_wr = 1; clr_id = 26; tick(1); clr_wr = 0;
    chk("R3 clear of level id ignored", 128'(pend[26]), 128'(1));
    p_hyp = 0; p_ns = 1; tick(2);
    chk("R5 ns timer at id30", 128'(pend[31:25]), 128'(7'b010_0000));
    p_ns = 0; tick(2);

    // enable the interface
    if_en_wr = 1; if_en_val = 1; tick(1); if_en_wr = 0;
    chk("R12 R7 bypass off after enable", 128'({fiq_req, irq_req}), 128'(0));
    chk("R6 fiq pending at id28", 128'(pend[28]), 128'(1));
    irq_n = 0; tick(2);
    chk("R6 irq pending at id31", 128'(pend[31]), 128'(1));
    irq_n = 1; fiq_n = 1; tick(2);
    chk("R6 legacy released", 128'(pend[31:25]), 128'(0));

    // shared level line
    spi_in[3] = 1; tick(2);
    chk("R9 level line at id35", 128'(pend[35]), 128'(1));
    clr_wr = 1; clr_id = 35; tick(1); clr_wr = 0;
    chk("R3 clear of level spi ignored", 128'(pend[35]), 128'(1));
    spi_in[3] = 0; tick(2);
    chk("R9 level line drops", 128'(pend[35]), 128'(0));

    // shared edge line
    spi_cfg[10] = 1; spi_in[10] = 1; tick(2);
    chk("R10 edge not yet", 128'(pend[42]), 128'(0));
    tick(1);
    chk("R10 edge latched", 128'(pend[42]), 128'(1));
    spi_in[10] = 0; tick(3);
    chk("R10 edge sticky", 128'(pend[42]), 128'(1));
    clr_wr = 1; clr_id = 42; tick(1); clr_wr = 0;
    chk("R3 edge clear", 128'(pend[42]), 128'(0));
    spi_in[10] = 1; tick(2);
    clr_wr = 1; clr_id = 42; tick(1); clr_wr = 0;
    chk("R4 edge beats clear", 128'(pend[42]), 128'(1));
    spi_in[10] = 0; tick(2);
    spi_cfg[10] = 0; tick(1);
    spi_cfg[10] = 1; #1;
    chk("R11 no stale edge state", 128'(pend[42]), 128'(0));
    tick(1);

    // random traffic against the model
    for (int cyc = 0; cyc < 3000; cyc++) begin
      chk("R2 R5 R9 R10 random pend", 128'(pend), 128'(exp_pend()));
      chk("R7 random req", 128'({fiq_req, irq_req}),
          128'(m_en ? 2'b00 : {~fiq_n, ~irq_n}));
      sgi_wr = ($urandom % 8) == 0;
      sgi_id = 4'($urandom);
      clr_wr = ($urandom % 4) == 0;
      clr_id = IDW'($urandom % NI);
      spi_in = spi_in ^ (NS'({$urandom, $urandom}) & NS'({$urandom, $urandom}) &
                         NS'({$urandom, $urandom}));
      if (($urandom % 64) == 0) spi_cfg[$urandom % NS] ^= 1'b1;
      if (($urandom % 16) == 0) p_maint = ~p_maint;
      if (($urandom % 16) == 0) p_virt = ~p_virt;
      if (($urandom % 16) == 0) p_sec = ~p_sec;
      if (($urandom % 16) == 0) fiq_n = ~fiq_n;
      if (($urandom % 16) == 0) irq_n = ~irq_n;
      if_en_wr = ($urandom % 100) == 0;
      if_en_val = 1'($urandom);
      tick(1);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule